// File: doc/BRIEF.md
# Genetic Training Generation Sequencer

This block runs the generation loop of a hardware genetic algorithm that tunes the weights of a small neuron. It keeps a population of six chromosomes. Each chromosome is one row of the population store and holds the full weight set of the neuron: three 8-bit signed weights. An external neuron evaluator and an external offspring engine do the arithmetic. The sequencer only decides what runs when, scores the results and ranks the population.

A run starts with a pulse on `go`, which loads a seed population. The sequencer hands each chromosome in turn to the evaluator through a start/done handshake and scores each one by the absolute difference between the evaluator's output and the target. When all six results are in, it ranks the population with a sequential insertion sort. If the best error is within the tolerance, it stops and presents the winning weights. If not, it either gives up after a programmable number of generations or offers the four best chromosomes to the offspring engine as parents and waits for the next generation.

Top module: `ga_train_seq`

## Requirements
- R1: After reset, `forming`, `analysis`, `finished`, `failed`, `breed_req` and `eval_start` are all low.
- R2: A `go` pulse while idle loads `seed_pop` (chromosome k at bits [24k+23:24k]; weight w at bits [8w+7:8w] of a chromosome). The chromosomes are then presented on `eval_weights` in index order 0 to 5. Each presentation has a one-cycle `eval_start`, and the next presentation waits for `eval_done`.
- R3: `forming` is high from the cycle after `go` until the `eval_done` of chromosome 5 is taken. On that same edge `forming` falls and `analysis` rises. The two flags are never high together.
- R4: `analysis` stays high for exactly seven cycles per generation: six insertion steps and one decision cycle.
- R5: The error of a chromosome is |`eval_out` − `target`|. If the smallest error of a generation is less than or equal to `tolerance`, `finished` rises with `failed` low. In that case `best_weights` carries that chromosome and `best_err` carries its error.
- R6: Ranking is ascending by error. Among equal errors, the lower chromosome index ranks first.
- R7: While `breed_req` is high, `parents` carries the four best-ranked chromosomes, with rank r at bits [24r+23:24r].
- R8: `breed_req` stays high until `eval_done`-style acknowledge `breed_done` arrives. The `breed_pop` present at that edge replaces the population, and evaluation restarts at chromosome 0. `gen_count` counts the breed requests issued since `go`.
- R9: If no chromosome meets the tolerance after `max_gen` evaluated generations, the block sets `finished` and `failed` together and presents the best-ranked chromosome of the last generation. A `max_gen` of 0 behaves as 1.
- R10: Once `finished` is set, it holds high, together with `failed`, `best_weights` and `best_err`, until the next `go`. During that time `forming`, `analysis` and `breed_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| go | input | 1 | Start a training run (taken while idle) |
| seed_pop | input | 144 | Initial population, six packed chromosomes |
| target | input | 7 | Required neuron output, 0 to 100 |
| tolerance | input | 7 | Largest error accepted as a success |
| max_gen | input | 8 | Generation limit before giving up |
| eval_start | output | 1 | One-cycle request to the neuron evaluator |
| eval_weights | output | 24 | Chromosome under evaluation |
| eval_done | input | 1 | Evaluator result valid |
| eval_out | input | 7 | Evaluator output for the presented chromosome |
| breed_req | output | 1 | Request for a new generation |
| parents | output | 96 | Four ranked parent chromosomes |
| breed_done | input | 1 | New generation valid on `breed_pop` |
| breed_pop | input | 144 | New population from the offspring engine |
| forming | output | 1 | Chromosomes are being run through the neuron |
| analysis | output | 1 | Results are being ranked and judged |
| finished | output | 1 | Training has stopped |
| failed | output | 1 | Training stopped on the generation limit |
| best_weights | output | 24 | Weights applied to the neuron at the stop |
| best_err | output | 7 | Error of `best_weights` |
| gen_count | output | 8 | Breed requests issued in this run |

## Verification
The bench first targets equal errors. Two chromosomes tie on the minimum error within tolerance, so a sorter that does not keep insertion stable would pick the later index and apply the wrong weights. It checks the `parents` order after a failed generation where ties sit at the top of the ranking; a broken shift would duplicate or drop a parent. It checks the phase edge, where a design that opened analysis one cycle late, or let the phases overlap, would miss the exact seven-cycle analysis window. Last, it runs the generation limit both at 2 and at 0, where an off-by-one count would request one breed too many, or never stop.

// File: rtl/ga_seq_pkg.sv
// Shared types of the genetic training sequencer.
package ga_seq_pkg;
    // Sequencer phases: idle, present, await result, rank, judge, await offspring
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ISSUE  = 3'd1,
        ST_WAIT   = 3'd2,
        ST_SORT   = 3'd3,
        ST_DECIDE = 3'd4,
        ST_BREED  = 3'd5
    } seq_state_t;
endpackage

// File: rtl/ga_abs_err.sv
// Absolute difference of two unsigned values.
// Assumes both operands share width W, so the result fits in W bits.
module ga_abs_err #(
    parameter int W = 7
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] d
);
    // Subtract the smaller operand from the larger one
    always_comb begin
        if (a >= b) d = a - b;
        else        d = b - a;
    end
endmodule

// File: rtl/ga_pop_store.sv
// Population store: NCHROM rows of CBITS bits, replaced as a whole on ld_en.
// Assumes the loader presents all rows at once on a flat bus.
module ga_pop_store #(
    parameter int NCHROM = 6,
    parameter int CBITS  = 24,
    localparam int POPB  = NCHROM * CBITS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [POPB-1:0] ld_bus,
    output logic [POPB-1:0] pop_bus
);
    logic [CBITS-1:0] row_q [NCHROM];

    // Load every row in parallel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCHROM; k++) row_q[k] <= '0;
        end else if (ld_en) begin
            for (int k = 0; k < NCHROM; k++) row_q[k] <= ld_bus[k*CBITS +: CBITS];
        end
    end

    for (genvar k = 0; k < NCHROM; k++) begin : g_flat
        assign pop_bus[k*CBITS +: CBITS] = row_q[k];
    end
endmodule

// File: rtl/ga_rank_sort.sv
// Sequential insertion sort of (error, index) pairs, one insertion per cycle.
// A new pair goes in front of the first stored pair with a strictly larger error,
// so ties keep arrival order. Assumes pairs arrive in ascending index order and
// at most N insertions follow each clr.
module ga_rank_sort #(
    parameter int N  = 6,
    parameter int EW = 7,
    parameter int IW = 3,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          ins,
    input  logic [EW-1:0] ins_err,
    input  logic [IW-1:0] ins_idx,
    output logic [N*IW-1:0] rank_idx,
    output logic [N*EW-1:0] rank_err
);
    logic [EW-1:0] err_q  [N];
    logic [IW-1:0] idx_q  [N];
    logic [EW-1:0] err_nx [N];
    logic [IW-1:0] idx_nx [N];
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] ins_pos;

    // Locate the slot the new pair takes
    always_comb begin
        ins_pos = cnt_q;
        for (int s = N - 1; s >= 0; s--) begin
            if (CW'(s) < cnt_q && err_q[s] > ins_err) ins_pos = CW'(s);
        end
    end

    // Build the shifted list with the new pair in place
    always_comb begin
        for (int s = 0; s < N; s++) begin
            err_nx[s] = err_q[s];
            idx_nx[s] = idx_q[s];
            if (CW'(s) == ins_pos) begin
                err_nx[s] = ins_err;
                idx_nx[s] = ins_idx;
            end else if (s > 0 && CW'(s) > ins_pos) begin
                err_nx[s] = err_q[s-1];
                idx_nx[s] = idx_q[s-1];
            end
        end
    end

    // Commit an insertion and track the fill level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int s = 0; s < N; s++) begin
                err_q[s] <= '0;
                idx_q[s] <= '0;
            end
        end else if (clr) begin
            cnt_q <= '0;
        end else if (ins && cnt_q < CW'(N)) begin
            cnt_q <= cnt_q + 1'b1;
            for (int s = 0; s < N; s++) begin
                err_q[s] <= err_nx[s];
                idx_q[s] <= idx_nx[s];
            end
        end
    end

    for (genvar s = 0; s < N; s++) begin : g_out
        assign rank_idx[s*IW +: IW] = idx_q[s];
        assign rank_err[s*EW +: EW] = err_q[s];
    end
endmodule

// File: rtl/ga_train_seq.sv
// Generation sequencer of a hardware genetic algorithm.
// Presents each chromosome to an external evaluator, scores it by absolute error
// against the target, ranks the generation, then stops on success or on the
// generation limit, or requests offspring from the ranked parents.
// Assumes eval_done arrives only in reply to eval_start, and breed_done only
// while breed_req is high.
module ga_train_seq
    import ga_seq_pkg::*;
#(
    parameter int NCHROM  = 6,
    parameter int NWEIGHT = 3,
    parameter int WBITS   = 8,
    parameter int OBITS   = 7,
    parameter int GBITS   = 8,
    parameter int NPAR    = 4,
    localparam int CBITS  = NWEIGHT * WBITS,
    localparam int POPB   = NCHROM * CBITS,
    localparam int IW     = $clog2(NCHROM)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  go,
    input  logic [POPB-1:0]       seed_pop,
    input  logic [OBITS-1:0]      target,
    input  logic [OBITS-1:0]      tolerance,
    input  logic [GBITS-1:0]      max_gen,
    output logic                  eval_start,
    output logic [CBITS-1:0]      eval_weights,
    input  logic                  eval_done,
    input  logic [OBITS-1:0]      eval_out,
    output logic                  breed_req,
    output logic [NPAR*CBITS-1:0] parents,
    input  logic                  breed_done,
    input  logic [POPB-1:0]       breed_pop,
    output logic                  forming,
    output logic                  analysis,
    output logic                  finished,
    output logic                  failed,
    output logic [CBITS-1:0]      best_weights,
    output logic [OBITS-1:0]      best_err,
    output logic [GBITS-1:0]      gen_count
);
    seq_state_t        state_q;
    logic [IW-1:0]     cur_idx_q;
    logic [IW-1:0]     sort_cnt_q;
    logic [GBITS-1:0]  gen_q;
    logic [OBITS-1:0]  err_q [NCHROM];
    logic              fin_q, fail_q;
    logic [CBITS-1:0]  best_w_q;
    logic [OBITS-1:0]  best_e_q;

    logic [POPB-1:0]       pop_bus;
    logic [NCHROM*IW-1:0]  rank_idx;
    logic [NCHROM*OBITS-1:0] rank_err;
    logic [OBITS-1:0]  cur_err;
    logic              ld_en, last_done, sort_clr, sort_ins, hit, out_of_gens;
    logic [IW-1:0]     top_idx;
    logic [OBITS-1:0]  top_err;

    assign ld_en     = (state_q == ST_IDLE && go) || (state_q == ST_BREED && breed_done);
    assign last_done = (state_q == ST_WAIT) && eval_done && (cur_idx_q == IW'(NCHROM - 1));
    assign sort_clr  = last_done;
    assign sort_ins  = (state_q == ST_SORT);
    assign top_idx   = rank_idx[IW-1:0];
    assign top_err   = rank_err[OBITS-1:0];
    assign hit       = (top_err <= tolerance);
    assign out_of_gens = ({1'b0, gen_q} + 1'b1) >= {1'b0, max_gen};

    ga_pop_store #(.NCHROM(NCHROM), .CBITS(CBITS)) i_pop (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld_en  (ld_en),
        .ld_bus ((state_q == ST_IDLE) ? seed_pop : breed_pop),
        .pop_bus(pop_bus)
    );

    ga_abs_err #(.W(OBITS)) i_err (
        .a(eval_out),
        .b(target),
        .d(cur_err)
    );

    ga_rank_sort #(.N(NCHROM), .EW(OBITS), .IW(IW)) i_sort (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (sort_clr),
        .ins     (sort_ins),
        .ins_err (err_q[sort_cnt_q]),
        .ins_idx (sort_cnt_q),
        .rank_idx(rank_idx),
        .rank_err(rank_err)
    );

    // Capture each chromosome's error as its result returns
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NCHROM; k++) err_q[k] <= '0;
        end else if (state_q == ST_WAIT && eval_done) begin
            err_q[cur_idx_q] <= cur_err;
        end
    end

    // Phase control, generation counting and final result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cur_idx_q  <= '0;
            sort_cnt_q <= '0;
            gen_q      <= '0;
            fin_q      <= 1'b0;
            fail_q     <= 1'b0;
            best_w_q   <= '0;
            best_e_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (go) begin
                    fin_q     <= 1'b0;
                    fail_q    <= 1'b0;
                    gen_q     <= '0;
                    cur_idx_q <= '0;
                    state_q   <= ST_ISSUE;
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: if (eval_done) begin
                    if (cur_idx_q == IW'(NCHROM - 1)) begin
                        cur_idx_q  <= '0;
                        sort_cnt_q <= '0;
                        state_q    <= ST_SORT;
                    end else begin
                        cur_idx_q <= cur_idx_q + 1'b1;
                        state_q   <= ST_ISSUE;
                    end
                end
                ST_SORT: begin
                    sort_cnt_q <= sort_cnt_q + 1'b1;
                    if (sort_cnt_q == IW'(NCHROM - 1)) state_q <= ST_DECIDE;
                end
                ST_DECIDE: begin
                    if (hit || out_of_gens) begin
                        fin_q    <= 1'b1;
                        fail_q   <= !hit;
                        best_w_q <= pop_bus[top_idx*CBITS +: CBITS];
                        best_e_q <= top_err;
                        state_q  <= ST_IDLE;
                    end else begin
                        gen_q   <= gen_q + 1'b1;
                        state_q <= ST_BREED;
                    end
                end
                ST_BREED: if (breed_done) begin
                    cur_idx_q <= '0;
                    state_q   <= ST_ISSUE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Ranked parent selection for the offspring engine
    for (genvar r = 0; r < NPAR; r++) begin : g_par
        assign parents[r*CBITS +: CBITS] = pop_bus[rank_idx[r*IW +: IW]*CBITS +: CBITS];
    end

    assign eval_start   = (state_q == ST_ISSUE);
    assign eval_weights = pop_bus[cur_idx_q*CBITS +: CBITS];
    assign breed_req    = (state_q == ST_BREED);
    assign forming      = (state_q == ST_ISSUE) || (state_q == ST_WAIT);
    assign analysis     = (state_q == ST_SORT) || (state_q == ST_DECIDE);
    assign finished     = fin_q;
    assign failed       = fail_q;
    assign best_weights = best_w_q;
    assign best_err     = best_e_q;
    assign gen_count    = gen_q;
endmodule

// File: rtl/ga_train_seq_chk.sv
// Protocol and phase checker for ga_train_seq, attached by bind.
// Assumes the synchronous active-low reset of the sequencer.
module ga_train_seq_chk #(
    parameter int CBITS = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             go,
    input logic             eval_start,
    input logic             breed_req,
    input logic             breed_done,
    input logic             forming,
    input logic             analysis,
    input logic             finished,
    input logic             failed,
    input logic [CBITS-1:0] best_weights
);
    p_phase_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(forming && analysis));
    p_analysis_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(analysis) |-> $past(forming));
    p_start_in_forming_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start |-> forming);
    p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        eval_start |=> !eval_start);
    p_breed_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (breed_req && !breed_done) |=> breed_req);
    p_fail_is_fin_r9: assert property (@(posedge clk) disable iff (!rst_n)
        failed |-> finished);
    p_fin_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        finished |-> !(forming || analysis || breed_req));
    p_fin_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (finished && !go) |=> (finished && $stable(best_weights)));
endmodule

bind ga_train_seq ga_train_seq_chk #(.CBITS(CBITS)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .go          (go),
    .eval_start  (eval_start),
    .breed_req   (breed_req),
    .breed_done  (breed_done),
    .forming     (forming),
    .analysis    (analysis),
    .finished    (finished),
    .failed      (failed),
    .best_weights(best_weights)
);

// File: tb/test_ga_train_seq.sv
module test_ga_train_seq;
    localparam int NCH  = 6;
    localparam int CB   = 24;
    localparam int POPB = NCH * CB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic go = 1'b0;
    logic [POPB-1:0] seed_pop = '0;
    logic [6:0] target = '0, tolerance = '0;
    logic [7:0] max_gen = '0;
    logic eval_start, eval_done = 1'b0;
    logic [CB-1:0] eval_weights;
    logic [6:0] eval_out = '0;
    logic breed_req, breed_done = 1'b0;
    logic [4*CB-1:0] parents;
    logic [POPB-1:0] breed_pop = '0;
    logic forming, analysis, finished, failed;
    logic [CB-1:0] best_weights;
    logic [6:0] best_err;
    logic [7:0] gen_count;

    int n_chk = 0, n_bad = 0;
    logic [POPB-1:0] cur_pop;
    int pres = 0;
    int an_cyc = 0;

    always #2 clk = ~clk;

    ga_train_seq i_ga_train_seq (
        .clk(clk), .rst_n(rst_n), .go(go), .seed_pop(seed_pop), .target(target),
        .tolerance(tolerance), .max_gen(max_gen), .eval_start(eval_start),
        .eval_weights(eval_weights), .eval_done(eval_done), .eval_out(eval_out),
        .breed_req(breed_req), .parents(parents), .breed_done(breed_done),
        .breed_pop(breed_pop), .forming(forming), .analysis(analysis),
        .finished(finished), .failed(failed), .best_weights(best_weights),
        .best_err(best_err), .gen_count(gen_count)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // chromosome k: weight0 = b0 (evaluator output = its low 7 bits), other weights patterned
    function automatic logic [POPB-1:0] mkpop(input logic [47:0] b0s, input int g);
        logic [POPB-1:0] p;
        for (int k = 0; k < NCH; k++)
            p[k*CB +: CB] = {8'(k*37 + g*11 + 3), 8'(k*19 + 5), b0s[k*8 +: 8]};
        return p;
    endfunction

    // independent ranking model: repeated minimum selection, lowest index wins ties
    task automatic model_rank(input logic [POPB-1:0] p, input logic [6:0] tgt,
                              output int ord[NCH], output int errs[NCH]);
        bit used[NCH];
        for (int k = 0; k < NCH; k++) begin
            int o = int'(p[k*CB +: 7]);
            errs[k] = (o > int'(tgt)) ? o - int'(tgt) : int'(tgt) - o;
            used[k] = 1'b0;
        end
        for (int r = 0; r < NCH; r++) begin
            int b = -1;
            for (int k = 0; k < NCH; k++)
                if (!used[k] && (b < 0 || errs[k] < errs[b])) b = k;
            ord[r] = b;
            used[b] = 1'b1;
        end
    endtask

    // neuron evaluator model with order and phase checks
    task automatic evaluator();
        @(negedge clk);
        forever begin
            if (eval_start) begin
                chk(eval_weights == cur_pop[pres*CB +: CB], "R2 presentation order", eval_weights, cur_pop[pres*CB +: CB]);
                chk(forming && !analysis, "R3 forming during evaluation", {forming, analysis}, 2'b10);
                repeat (2) @(negedge clk);
                eval_out  = eval_weights[6:0];
                eval_done = 1'b1;
                @(negedge clk);
                eval_done = 1'b0;
                if (pres == NCH - 1)
                    chk(!forming && analysis, "R3 forming-to-analysis edge", {forming, analysis}, 2'b01);
                else
                    chk(forming && !analysis, "R3 forming holds between chromosomes", {forming, analysis}, 2'b10);
                pres++;
            end else begin
                @(negedge clk);
            end
        end
    endtask

    task automatic monitor();
        forever begin
            @(negedge clk);
            if (analysis) an_cyc++;
        end
    endtask

    // runs one training to its end; p1/p2 are the generations handed back on breed requests
    task automatic run_case(input string nm, input logic [POPB-1:0] p0, p1, p2,
                            input logic [6:0] tgt, tol, input logic [7:0] mg);
        logic [POPB-1:0] nxt [3];
        int ord[NCH], errs[NCH];
        int lim;
        bit done_run;
        nxt[0] = p0; nxt[1] = p1; nxt[2] = p2;
        target = tgt; tolerance = tol; max_gen = mg;
        seed_pop = p0; cur_pop = p0; pres = 0;
        lim = (mg == 0) ? 1 : int'(mg);
        @(negedge clk);
        go = 1'b1;
        @(negedge clk);
        go = 1'b0;
        an_cyc = 0;
        chk(forming && !finished, {"R2 ", nm, " run starts"}, {forming, finished}, 2'b10);
        done_run = 1'b0;
        for (int g = 0; g < 3 && !done_run; g++) begin
            bit stop_ok, stop_fail;
            model_rank(cur_pop, tgt, ord, errs);
            stop_ok   = errs[ord[0]] <= int'(tol);
            stop_fail = !stop_ok && (g + 1 >= lim);
            while (!(finished || breed_req)) @(negedge clk);
            if (stop_ok || stop_fail) begin
                chk(finished, {"R5 ", nm, " finished"}, finished, 1);
                chk(failed == stop_fail, {"R9 ", nm, " failed flag"}, failed, stop_fail);
                chk(best_weights == cur_pop[ord[0]*CB +: CB], {"R6 ", nm, " best weights"}, best_weights, cur_pop[ord[0]*CB +: CB]);
                chk(int'(best_err) == errs[ord[0]], {"R5 ", nm, " best error"}, best_err, errs[ord[0]]);
                chk(int'(gen_count) == g, {"R8 ", nm, " generation count"}, gen_count, g);
                chk(an_cyc == 7 * (g + 1), {"R4 ", nm, " analysis cycles"}, an_cyc, 7 * (g + 1));
                done_run = 1'b1;
            end else begin
                chk(breed_req && !finished, {"R8 ", nm, " breed request"}, {breed_req, finished}, 2'b10);
                for (int r = 0; r < 4; r++)
                    chk(parents[r*CB +: CB] == cur_pop[ord[r]*CB +: CB], {"R7 ", nm, " parent rank"},
                        parents[r*CB +: CB], cur_pop[ord[r]*CB +: CB]);
                repeat (2) @(negedge clk);
                chk(breed_req, {"R8 ", nm, " request held"}, breed_req, 1);
                breed_pop  = nxt[g+1];
                cur_pop    = nxt[g+1];
                pres       = 0;
                breed_done = 1'b1;
                @(negedge clk);
                breed_done = 1'b0;
            end
        end
        chk(done_run, {"R9 ", nm, " run completed"}, done_run, 1);
    endtask

    task automatic t_reset();
        chk(!forming && !analysis && !finished && !failed && !breed_req && !eval_start,
            "R1 reset state", {forming, analysis, finished, failed, breed_req, eval_start}, 0);
    endtask

    task automatic t_hold_after_finish();
        logic [CB-1:0] w = best_weights;
        logic f = failed;
        repeat (12) @(negedge clk);
        chk(finished && failed == f && best_weights == w && !forming && !analysis && !breed_req,
            "R10 result held until next go", {finished, best_weights}, {1'b1, w});
    endtask

    initial begin
        fork
            evaluator();
            monitor();
        join_none
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        // R6 tie on minimum error (indices 1 and 3) within tolerance; bit7 of weight0 ignored by evaluator
        run_case("tie-hit", mkpop({8'd60, 8'd70, 8'hAF, 8'd90, 8'd53, 8'd10}, 0), '0, '0, 7'd50, 7'd3, 8'd5);
        t_hold_after_finish();
        // R7 tied parents at the top of the ranking, success in the second generation
        run_case("breed-hit", mkpop({8'd17, 8'd23, 8'd40, 8'd5, 8'd25, 8'd30}, 0),
                 mkpop({8'd9, 8'd20, 8'd4, 8'd3, 8'd2, 8'd1}, 1), '0, 7'd20, 7'd0, 8'd4);
        // R9 generation limit of two
        run_case("limit2", mkpop({8'd60, 8'd50, 8'd40, 8'd30, 8'd20, 8'd10}, 0),
                 mkpop({8'd97, 8'd95, 8'd90, 8'd80, 8'd70, 8'd61}, 1), '0, 7'd100, 7'd1, 8'd2);
        t_hold_after_finish();
        // R9 limit of zero acts as one; all errors equal so index 0 wins
        run_case("limit0", mkpop({8'd5, 8'd5, 8'd5, 8'd5, 8'd5, 8'd5}, 0), '0, '0, 7'd0, 7'd0, 8'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule